// File: doc/BRIEF.md
# Interrupt status and mask registers

This block collects the event pulses of a serial bus master engine into a latched pending register and decides which pending events reach the processor. Each hardware event arrives as a one-cycle pulse on its own input bit and sets its pending bit. The pending bit then stays set until software writes a one to that bit position.

An enable mask selects which pending bits drive the single combined interrupt output. Software never writes the mask directly. One write-only port turns enable bits on, another turns them off, and a read-only view shows the current mask. A separate summary output reports whether any error-class event is pending, whatever the mask holds.

Access is through a simple register bus with an address, a write strobe, write data and combinational read data. Reset is asserted asynchronously and released synchronously to the clock.

Top module: `busm_irq_ctrl`

## Requirements
- R1: After reset the pending register and the mask read as zero, and both `irq` and `err_pending` are low.
- R2: A pulse on `evt_pulse[n]` for an implemented bit n sets pending bit n at the next clock edge, whatever the mask holds. The bit stays set until it is cleared. Pending bits are read at offset 0x10.
- R3: A bus write to offset 0x10 clears every pending bit whose write-data bit is one and leaves the bits written as zero unchanged.
- R4: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.
- R5: A write to offset 0x24 sets the mask bits that are one in the write data. A write to offset 0x28 clears the mask bits that are one. Zero bits leave the mask unchanged. The mask reads back at offset 0x20, and writes to 0x20 are ignored.
- R6: Reads of the write-only offsets 0x24 and 0x28, and reads of any unmapped offset, return zero.
- R7: `irq` is high exactly when at least one pending bit is also enabled in the mask. It follows a change of either in the cycle after the edge that makes the change.
- R8: `err_pending` is high exactly when at least one of the error-class pending bits is set, independent of the mask. The error-class bits are 9 (arbitration lost), 7 (receive underflow), 6 (transmit overflow), 5 (receive overflow) and 2 (no acknowledge).
- R9: The implemented bits are 0 to 7 and 9, named transfer complete (0), data threshold (1), no acknowledge (2), timeout (3), slave ready (4), receive overflow (5), transmit overflow (6), receive underflow (7) and arbitration lost (9). Bit 8 and bits 31 to 10 always read as zero in both the pending view and the mask view. Writes and event pulses do not set them.
- R10: Reading the pending register and writing the same value back to offset 0x10 clears every pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt_pulse | input | SRC_W | One-cycle event pulses, one bit per source |
| irq | output | 1 | Combined interrupt: any pending and enabled bit |
| err_pending | output | 1 | Any error-class bit pending, mask ignored |

## Verification
The pending logic is exercised with single-bit pulses and with all-ones pulses while the mask is empty. A partial clear and a clear that collides with a new event then show whether each bit's set and clear paths are kept apart and which one has priority. The mask is built up and torn down through its two ports while a bit stays pending, so that changes of `irq` can be traced either to the mask or to the pending register. Error-class and non-error events are applied separately with the mask empty, which shows that `err_pending` is decoded only from its own group of bits. Writing all-ones everywhere tests the reserved bits and the write-only offsets.

// File: rtl/busm_irq_pkg.sv
package busm_irq_pkg;

  // Number of source positions, including the reserved hole at bit 8.
  localparam int unsigned SRC_W = 10;

  // Positions that hold a real flop.
  localparam logic [SRC_W-1:0] SRC_IMPL = 10'h2FF;

  // Arbitration lost, receive underflow, transmit overflow,
  // receive overflow, no acknowledge.
  localparam logic [SRC_W-1:0] ERR_GROUP = 10'h2E4;

  typedef struct packed {
    logic stat_wr;
    logic ena_wr;
    logic dis_wr;
  } wr_sel_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2
  } rd_sel_t;

endpackage

// File: rtl/busm_irq_decode.sv
module busm_irq_decode
  import busm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENA  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 8'h28
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output wr_sel_t           wr_o,
  output rd_sel_t           rd_o
);

  always_comb begin
    wr_o.stat_wr = we_i && (addr_i == OFS_STAT);
    wr_o.ena_wr  = we_i && (addr_i == OFS_ENA);
    wr_o.dis_wr  = we_i && (addr_i == OFS_DIS);
  end

  // The set and clear ports are write-only, so they decode to zero.
  always_comb begin
    if (addr_i == OFS_STAT)      rd_o = RD_STAT;
    else if (addr_i == OFS_MASK) rd_o = RD_MASK;
    else                         rd_o = RD_ZERO;
  end

  always_comb begin
    a_r5_one_write_target: assert ($countones({wr_o.stat_wr, wr_o.ena_wr, wr_o.dis_wr}) <= 1);
  end

endmodule

// File: rtl/busm_irq_status.sv
module busm_irq_status #(
  parameter int unsigned SRC_W = 10,
  parameter logic [SRC_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] stat_o
);

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic bit_q;
      logic bit_d;
      logic bit_en;

      // An event beats a clear in the same cycle.
      always_comb begin
        bit_en = evt_i[i] | clr_i[i];
        bit_d  = evt_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end

      assign stat_o[i] = bit_q;

      a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[i] |=> stat_o[i]);
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !evt_i[i]) |=> !stat_o[i]);
      a_r2_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !evt_i[i]) |=> $stable(stat_o[i]));
    end else begin : g_hole
      logic unused_in;
      assign unused_in = evt_i[i] ^ clr_i[i];
      assign stat_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/busm_irq_mask.sv
module busm_irq_mask #(
  parameter int unsigned SRC_W = 10,
  parameter logic [SRC_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] mask_o
);

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic en_q;
      logic en_d;
      logic en_upd;

      always_comb begin
        en_upd = set_i[i] | clr_i[i];
        en_d   = set_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_upd) en_q <= en_d;
      end

      assign mask_o[i] = en_q;

      a_r5_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> mask_o[i]);
      a_r5_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !mask_o[i]);
    end else begin : g_hole
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign mask_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/busm_irq_ctrl.sv
module busm_irq_ctrl
  import busm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENA  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_W-1:0]  evt_pulse,
  output logic              irq,
  output logic              err_pending
);

  localparam int unsigned PAD_W = DATA_W - SRC_W;

  // Reset: asserted at once, released on the second clock edge.
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  wr_sel_t          wr_sel;
  rd_sel_t          rd_sel;
  logic [SRC_W-1:0] wbits;
  logic [SRC_W-1:0] stat_clr;
  logic [SRC_W-1:0] mask_set;
  logic [SRC_W-1:0] mask_clr;
  logic [SRC_W-1:0] stat_q;
  logic [SRC_W-1:0] mask_q;
  logic             unused_wdata_hi;

  assign wbits           = bus_wdata[SRC_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SRC_W];

  busm_irq_decode #(
    .ADDR_W  (ADDR_W),
    .OFS_STAT(OFS_STAT),
    .OFS_MASK(OFS_MASK),
    .OFS_ENA (OFS_ENA),
    .OFS_DIS (OFS_DIS)
  ) u_decode (
    .addr_i(bus_addr),
    .we_i  (bus_we),
    .wr_o  (wr_sel),
    .rd_o  (rd_sel)
  );

  always_comb begin
    stat_clr = wr_sel.stat_wr ? wbits : '0;
    mask_set = wr_sel.ena_wr  ? wbits : '0;
    mask_clr = wr_sel.dis_wr  ? wbits : '0;
  end

  busm_irq_status #(
    .SRC_W(SRC_W),
    .IMPL (SRC_IMPL)
  ) u_status (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_i (evt_pulse),
    .clr_i (stat_clr),
    .stat_o(stat_q)
  );

  busm_irq_mask #(
    .SRC_W(SRC_W),
    .IMPL (SRC_IMPL)
  ) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .mask_o(mask_q)
  );

  always_comb begin
    unique case (rd_sel)
      RD_STAT: bus_rdata = {{PAD_W{1'b0}}, stat_q};
      RD_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq         = |(stat_q & mask_q);
  assign err_pending = |(stat_q & ERR_GROUP);

  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq);
  a_r8_err_needs_pending: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_pending |-> (stat_q != '0));
  a_r1_clean_after_reset: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (stat_q == '0) && (mask_q == '0));

endmodule

// File: tb/busm_irq_ctrl_bench.sv
module busm_irq_ctrl_bench;

  localparam logic [7:0] A_STAT = 8'h10;
  localparam logic [7:0] A_MASK = 8'h20;
  localparam logic [7:0] A_ENA  = 8'h24;
  localparam logic [7:0] A_DIS  = 8'h28;
  localparam logic [31:0] IMPL  = 32'h0000_02FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [9:0]  evt_pulse;
  logic        irq;
  logic        err_pending;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  busm_irq_ctrl u_busm_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_pulse  (evt_pulse),
    .irq        (irq),
    .err_pending(err_pending)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_STAT, d); check("R1 status after reset", d, 32'h0);
    rd(A_MASK, d); check("R1 mask after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 err_pending after reset", {31'b0, err_pending}, 32'h0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse(10'h001);
    pulse(10'h010);
    rd(A_STAT, d); check("R2 single pulses latch unmasked", d, 32'h011);
    check("R7 irq low with empty mask", {31'b0, irq}, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); check("R2 bits hold without clear", d, 32'h011);
    wr(A_STAT, 32'h11);
  endtask

  task automatic t_partial_clear;
    logic [31:0] d;
    pulse(10'h0CB);
    wr(A_STAT, 32'h0000_0042);
    rd(A_STAT, d); check("R3 partial clear", d, 32'h089);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R3 zero write keeps bits", d, 32'h089);
    wr(A_STAT, 32'h89);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    pulse(10'h002);
    @(negedge clk);
    evt_pulse = 10'h008;
    bus_addr  = A_STAT;
    bus_we    = 1'b1;
    bus_wdata = 32'h0000_000A;
    @(negedge clk);
    evt_pulse = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    rd(A_STAT, d); check("R4 set beats clear, other bit clears", d, 32'h008);
    wr(A_STAT, 32'h8);
    rd(A_STAT, d); check("R3 clear after collision", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(A_ENA, 32'h0000_0015);
    rd(A_MASK, d); check("R5 enable port sets bits", d, 32'h015);
    wr(A_ENA, 32'h0000_0020);
    rd(A_MASK, d); check("R5 enable adds without clearing", d, 32'h035);
    wr(A_DIS, 32'h0000_0011);
    rd(A_MASK, d); check("R5 disable port clears ones only", d, 32'h024);
    wr(A_MASK, 32'h0000_00FF);
    rd(A_MASK, d); check("R5 write to mask view ignored", d, 32'h024);
    wr(A_DIS, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R5 disable all", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(A_ENA, 32'h10);
    check("R7 enabled but nothing pending", {31'b0, irq}, 32'h0);
    pulse(10'h010);
    check("R7 irq rises on enabled event", {31'b0, irq}, 32'h1);
    wr(A_DIS, 32'h10);
    check("R7 irq drops on disable", {31'b0, irq}, 32'h0);
    rd(A_STAT, d); check("R2 pending survives disable", d, 32'h010);
    wr(A_ENA, 32'h10);
    check("R7 irq returns on re-enable", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h10);
    check("R7 irq drops on clear", {31'b0, irq}, 32'h0);
    wr(A_DIS, 32'h10);
  endtask

  task automatic t_err;
    pulse(10'h004);
    check("R8 NACK raises err_pending", {31'b0, err_pending}, 32'h1);
    check("R7 irq low while masked", {31'b0, irq}, 32'h0);
    wr(A_STAT, 32'h4);
    check("R8 err_pending drops", {31'b0, err_pending}, 32'h0);
    pulse(10'h01B);
    check("R8 non-error events leave err low", {31'b0, err_pending}, 32'h0);
    wr(A_STAT, 32'h1B);
    pulse(10'h200);
    check("R8 arbitration lost raises err", {31'b0, err_pending}, 32'h1);
    wr(A_STAT, 32'h200);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    pulse(10'h3FF);
    rd(A_STAT, d); check("R9 status reserved bits zero", d, IMPL);
    wr(A_ENA, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R9 mask reserved bits zero", d, IMPL);
    pulse(10'h100);
    rd(A_STAT, d); check("R9 bit 8 event ignored", d, IMPL);
  endtask

  task automatic t_writeback;
    logic [31:0] d;
    logic [31:0] v;
    rd(A_STAT, v);
    wr(A_STAT, v);
    rd(A_STAT, d); check("R10 read then write back clears all", d, 32'h0);
    check("R10 irq low after write back", {31'b0, irq}, 32'h0);
    wr(A_DIS, 32'hFFFF_FFFF);
  endtask

  task automatic t_wo_reads;
    logic [31:0] d;
    wr(A_ENA, 32'h3);
    rd(A_ENA, d); check("R6 enable port reads zero", d, 32'h0);
    rd(A_DIS, d); check("R6 disable port reads zero", d, 32'h0);
    rd(8'h14, d); check("R6 unmapped offset reads zero", d, 32'h0);
    rd(A_MASK, d); check("R5 mask intact after reads", d, 32'h3);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    evt_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latch();
    t_partial_clear();
    t_set_wins();
    t_mask();
    t_irq();
    t_err();
    t_reserved();
    t_writeback();
    t_wo_reads();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule